// File: doc/BRIEF.md
# Banked Level Interrupt Aggregator

This block gathers level-sensitive interrupt requests from a set of peripherals and folds them into one request line toward a processor. The sources are split into banks of equal width. With the default sizes there are 64 sources in two banks of 32. Source number k belongs to bank k/32, at bit position k mod 32. Every source has one enable bit. A source counts as pending while its raw input is high and its enable bit is set. The processor output is raised while any source is pending.

Software works through a small word-addressed register port. Enable bits are never written directly. Each bank has a set-enable word and a clear-enable word. Writing ones to the set word turns those sources on, and writing ones to the clear word turns them off. Zero bits in either write leave the matching source unchanged, so no read-modify-write is needed. Reading either word returns the bank's current enable mask.

Each bank also has a pending word that can be read. A summary word shows which bank needs servicing. The interrupt handler reads the summary first, then reads only the pending word of the flagged bank.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After synchronous reset every enable bit is 0, `irq_o` is 0, and `rd_data` is 0.
- R2: Source k is bit k of `src_i`. It is reported in bank k/32 at bit k mod 32. With the default sizes, source 31 is bank 0 bit 31 and source 32 is bank 1 bit 0.
- R3: A write to word 3+b (the set-enable word of bank b, for b = 0 or 1) sets every enable bit of bank b whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R4: A write to word 5+b (the clear-enable word of bank b) clears every enable bit of bank b whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R5: Reading word 1+b (the pending word of bank b) returns the raw source levels of bank b ANDed with their enable bits. A bit falls again as soon as its source goes low.
- R6: `irq_o` is the OR of all pending bits across all banks. It follows source and enable changes in the same cycle, with no register on the path.
- R7: Reading word 0 (the summary word) returns bit 8 set exactly when bank 0 has any pending bit, and bit 9 set exactly when bank 1 has any pending bit. All other bits read 0.
- R8: Reading the set-enable word or the clear-enable word of a bank returns that bank's current enable mask.
- R9: Read data appears on `rd_data` one clock after `rd_en` is sampled high, and holds its value while `rd_en` is low. Word addresses 7 and above read 0.
- R10: The enable mask changes only on writes to the set-enable or clear-enable words. Writes to the summary word, to the pending words, or to addresses 7 and above leave every enable bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Raw level of each source, bit k = source k |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Request to the processor, high while any source is pending |

## Verification
The bench builds the block with its default sizes: two banks of 32 sources and a 4-bit word address. These sizes make every address class reachable, including the first unmapped word (7) and the upper end of the address range. They also expose the bank seam at sources 31 and 32, where a bank-index error would move a request into the wrong pending word or set the wrong summary bit. With two banks, the summary can be checked in all of its states: neither bank pending, one bank pending, the other bank pending, and both pending.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int IC_NUM_BANKS = 2;
    localparam int IC_BANK_W    = 32;
    localparam int IC_ADDR_W    = 4;
    localparam int IC_SUM_LSB   = 8;

    typedef enum logic [2:0] {
        K_SUM  = 3'd0,
        K_PEND = 3'd1,
        K_SET  = 3'd2,
        K_CLR  = 3'd3,
        K_NONE = 3'd4
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] bank;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input int unsigned a, input int unsigned nb);
        reg_sel_t s;
        s.kind = K_NONE;
        s.bank = '0;
        if (a == 0) begin
            s.kind = K_SUM;
        end else if (a <= nb) begin
            s.kind = K_PEND;
            s.bank = 8'(a - 1);
        end else if (a <= 2 * nb) begin
            s.kind = K_SET;
            s.bank = 8'(a - 1 - nb);
        end else if (a <= 3 * nb) begin
            s.kind = K_CLR;
            s.bank = 8'(a - 1 - 2 * nb);
        end
        return s;
    endfunction

endpackage

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] mask,
    output logic [W-1:0] en_o
);
    logic [W-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (set_stb) begin
            en_q <= en_q | mask;
        end else if (clr_stb) begin
            en_q <= en_q & ~mask;
        end
    end

    assign en_o = en_q;
endmodule

// File: rtl/irq_pend_sum.sv
module irq_pend_sum #(
    parameter int NB = 2,
    parameter int W  = 32,
    localparam int NS = NB * W
) (
    input  logic [NS-1:0] src_i,
    input  logic [NS-1:0] en_i,
    output logic [NS-1:0] pend_o,
    output logic [NB-1:0] bank_any_o,
    output logic          irq_o
);
    assign pend_o = src_i & en_i;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign bank_any_o[b] = |pend_o[b*W +: W];
    end

    assign irq_o = |bank_any_o;
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_bank_pkg::*;
#(
    parameter int NB      = 2,
    parameter int W       = 32,
    parameter int AW      = 4,
    parameter int SUM_LSB = 8,
    localparam int NS     = NB * W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [NS-1:0] en_all,
    input  logic [NS-1:0] pend_all,
    input  logic [NB-1:0] bank_any,
    output logic [NB-1:0] set_stb,
    output logic [NB-1:0] clr_stb,
    output logic [W-1:0]  rd_data
);
    reg_sel_t     sel;
    logic [W-1:0] rd_val;
    logic [W-1:0] rd_q;

    always_comb begin
        sel = decode_addr(int'(unsigned'(addr)), NB);
        for (int b = 0; b < NB; b++) begin
            set_stb[b] = wr_en && (sel.kind == K_SET) && (sel.bank == 8'(b));
            clr_stb[b] = wr_en && (sel.kind == K_CLR) && (sel.bank == 8'(b));
        end
    end

    always_comb begin
        rd_val = '0;
        case (sel.kind)
            K_SUM: begin
                for (int b = 0; b < NB; b++) rd_val[SUM_LSB + b] = bank_any[b];
            end
            K_PEND: begin
                for (int b = 0; b < NB; b++)
                    if (sel.bank == 8'(b)) rd_val = pend_all[b*W +: W];
            end
            K_SET, K_CLR: begin
                for (int b = 0; b < NB; b++)
                    if (sel.bank == 8'(b)) rd_val = en_all[b*W +: W];
            end
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_val;
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irq_bank_pkg::*;
#(
    parameter int NUM_BANKS = IC_NUM_BANKS,
    parameter int BANK_W    = IC_BANK_W,
    parameter int ADDR_W    = IC_ADDR_W,
    parameter int SUM_LSB   = IC_SUM_LSB,
    localparam int NUM_SRC  = NUM_BANKS * BANK_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BANK_W-1:0]  wr_data,
    output logic [BANK_W-1:0]  rd_data,
    output logic               irq_o
);
    logic [NUM_SRC-1:0]   en_all;
    logic [NUM_SRC-1:0]   pend_all;
    logic [NUM_BANKS-1:0] bank_any;
    logic [NUM_BANKS-1:0] set_stb;
    logic [NUM_BANKS-1:0] clr_stb;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_en
        irq_en_bank #(.W(BANK_W)) u_en (
            .clk     (clk),
            .rst     (rst),
            .set_stb (set_stb[b]),
            .clr_stb (clr_stb[b]),
            .mask    (wr_data),
            .en_o    (en_all[b*BANK_W +: BANK_W])
        );
    end

    irq_pend_sum #(.NB(NUM_BANKS), .W(BANK_W)) u_pend (
        .src_i      (src_i),
        .en_i       (en_all),
        .pend_o     (pend_all),
        .bank_any_o (bank_any),
        .irq_o      (irq_o)
    );

    irq_reg_port #(.NB(NUM_BANKS), .W(BANK_W), .AW(ADDR_W), .SUM_LSB(SUM_LSB)) u_port (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .en_all   (en_all),
        .pend_all (pend_all),
        .bank_any (bank_any),
        .set_stb  (set_stb),
        .clr_stb  (clr_stb),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk #(
    parameter int NB     = 2,
    parameter int W      = 32,
    parameter int AW     = 4,
    localparam int NS    = NB * W
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic [AW-1:0] addr,
    input logic [W-1:0]  wr_data,
    input logic [W-1:0]  rd_data,
    input logic          irq_o,
    input logic [NS-1:0] en_all
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (en_all == '0 && rd_data == '0)); // R1

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(en_all)); // R10

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (en_all == '0) |-> !irq_o); // R6

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R9

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam int SET_A = 1 + NB + b;
        localparam int CLR_A = 1 + 2 * NB + b;

        AST_SET_ONES: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == AW'(SET_A)) |=>
            ((en_all[b*W +: W] & $past(wr_data)) == $past(wr_data))); // R3

        AST_SET_ZEROS: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == AW'(SET_A)) |=>
            ((en_all[b*W +: W] & ~$past(wr_data)) ==
             ($past(en_all[b*W +: W]) & ~$past(wr_data)))); // R3

        AST_CLR_ONES: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == AW'(CLR_A)) |=>
            ((en_all[b*W +: W] & $past(wr_data)) == '0)); // R4

        AST_CLR_ZEROS: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == AW'(CLR_A)) |=>
            ((en_all[b*W +: W] & ~$past(wr_data)) ==
             ($past(en_all[b*W +: W]) & ~$past(wr_data)))); // R4
    end
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(.NB(NUM_BANKS), .W(BANK_W), .AW(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq_o   (irq_o),
    .en_all  (en_all)
);

// File: tb/irq_bank_ctrl_tb.sv
module irq_bank_ctrl_tb;
    localparam int NB = 2;
    localparam int W  = 32;
    localparam int NS = NB * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_i = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [3:0]    addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  rd_data;
    logic          irq_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [NS-1:0] m_en = '0;
    logic [W-1:0]  exp_q[$];
    string         tag_q[$];
    bit            done = 1'b0;

    always #10 clk = ~clk;

    irq_bank_ctrl u_dut (
        .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [W-1:0] model_read(input int a);
        logic [NS-1:0] p;
        logic [W-1:0]  v;
        p = src_i & m_en;
        v = '0;
        if (a == 0) begin
            v[8] = |p[W-1:0];
            v[9] = |p[NS-1:W];
        end else if (a >= 1 && a <= 2) begin
            v = p[(a-1)*W +: W];
        end else if (a >= 3 && a <= 4) begin
            v = m_en[(a-3)*W +: W];
        end else if (a >= 5 && a <= 6) begin
            v = m_en[(a-5)*W +: W];
        end
        return v;
    endfunction

    task automatic rd(input int a, input string tag);
        @(negedge clk);
        rd_en = 1'b1;
        addr  = 4'(a);
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input int a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        addr    = 4'(a);
        wr_data = d;
        if (a >= 3 && a <= 4) m_en[(a-3)*W +: W] = m_en[(a-3)*W +: W] | d;
        if (a >= 5 && a <= 6) m_en[(a-5)*W +: W] = m_en[(a-5)*W +: W] & ~d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_irq(input string tag);
        check(tag, {31'd0, irq_o}, {31'd0, |(src_i & m_en)});
    endtask

    // monitor: pops one expected item per read the design accepted
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en && !rst) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check("scoreboard underflow", rd_data, 'x);
                end else begin
                    check(tag_q.pop_front(), rd_data, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 rd_data after reset", rd_data, '0);
        chk_irq("R1 irq after reset");
        for (int a = 0; a < 7; a++) rd(a, "R1 register zero after reset");

        // all sources high, nothing enabled
        src_i = '1;
        @(negedge clk);
        chk_irq("R5 irq with no enables");
        rd(1, "R5 pending bank0 masked");
        rd(2, "R5 pending bank1 masked");

        // enable sources 1 and 3
        wr(3, 32'h0000_000A);
        rd(3, "R3 R8 set word shows mask");
        rd(5, "R8 clear word shows mask");
        rd(1, "R5 pending bank0 = src & en");
        chk_irq("R6 irq from bank0");
        wr(3, 32'h0);
        rd(3, "R3 zero write keeps mask");

        // sources 49 and 57 in bank 1
        wr(4, 32'h0202_0000);
        src_i = '0;
        src_i[57] = 1'b1;
        @(negedge clk);
        chk_irq("R6 irq from source 57");
        rd(2, "R2 source 57 at bank1 bit25");
        rd(1, "R2 bank0 empty");
        rd(0, "R7 summary bank1 only");

        wr(6, 32'h0200_0000);
        chk_irq("R4 irq off after clear");
        rd(6, "R4 clear word mask after clear");
        wr(6, 32'h0);
        rd(4, "R4 zero clear keeps mask");

        // bank seam: sources 31 and 32
        wr(3, 32'h8000_0000);
        wr(4, 32'h0000_0001);
        src_i = '0;
        src_i[31] = 1'b1;
        @(negedge clk);
        rd(1, "R2 source 31 bank0 bit31");
        rd(0, "R7 summary bank0 only");
        src_i[31] = 1'b0;
        src_i[32] = 1'b1;
        @(negedge clk);
        rd(2, "R2 source 32 bank1 bit0");
        rd(1, "R5 level drop clears pending");
        rd(0, "R7 summary follows seam");

        // source 29 enable, drop
        wr(3, 32'h2000_0000);
        src_i = '0;
        src_i[29] = 1'b1;
        @(negedge clk);
        chk_irq("R6 irq source 29");
        src_i[29] = 1'b0;
        @(negedge clk);
        chk_irq("R5 R6 irq follows level drop");

        // writes to non-enable words change nothing
        wr(0, '1);
        wr(1, '1);
        wr(2, '1);
        wr(7, '1);
        wr(15, '1);
        rd(3, "R10 bank0 mask after stray writes");
        rd(4, "R10 bank1 mask after stray writes");
        rd(7, "R9 unmapped reads zero");
        rd(12, "R9 high unmapped reads zero");

        // everything on
        wr(3, '1);
        wr(4, '1);
        src_i = '1;
        @(negedge clk);
        rd(0, "R7 summary both banks");
        held = model_read(0);
        src_i = '0;
        repeat (3) @(negedge clk);
        check("R9 rd_data holds without rd_en", rd_data, held);
        chk_irq("R6 irq low with sources low");

        repeat (2) @(negedge clk);
        check("scoreboard drained", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule